// File: doc/BRIEF.md
# Adjacent Instruction Pair Fuser

This unit sits in the decode stage of a 32-bit in-order integer pipeline. Each cycle it is given two 32-bit instruction words that are next to each other in program order. It decides whether the two can issue together as one macro-operation. It recognises two pairings.

The first is an unsigned set-less-than that produces a carry, followed at once by an add that folds that carry into a sum. This becomes a single three-source carry-add. The second is a conditional branch that jumps forward over exactly one instruction. This becomes a predicated form of the skipped instruction, which commits only when the branch is not taken.

All results are registered. One clock edge after a pair is sampled, the unit presents the following:
- a one-cycle fuse flag;
- a slot-advance signal that tells fetch to step two slots;
- the fused-operation kind;
- the destination and source register numbers;
- the branch condition code and the guarded instruction word.

When nothing matches, the flag stays low and fetch advances one slot. The two instructions then execute one after the other as normal.

Top module: `pair_fuse_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero at that edge; the cycle after reset is released, the outputs still read zero until a pair has been sampled with `rst_n` high.
- R2: Carry-add fusion. Slot A is SLTU: opcode 0110011, funct3 011, funct7 0000000, with destination d. Slot B is ADD: opcode 0110011, funct3 000, funct7 0000000, with destination d. Exactly one ADD source equals d. One edge later the outputs are:
  - `fuse_valid`=1 and `consume_two`=1;
  - `fuse_kind`=2'b01 and `fuse_rd`=d;
  - `fuse_rs1` and `fuse_rs2` equal the SLTU sources;
  - `fuse_rs3` equals the other ADD source, whichever operand position d occupies;
  - `cond_code` and `body_word` are zero.
- R3: The pair is not fused if it would write more than one register or would read a stale value. This covers three cases: the ADD destination differs from the SLTU destination; neither ADD source is d; or both ADD sources are d.
- R4: A destination of x0 in either instruction of a carry-add pair, or in the body of a skip pair, prevents fusion.
- R5: Skip fusion. Slot A has opcode 1100011 and a condition code in {000,001,100,101,110,111}. Its B-type immediate is +8. For that immediate, bit 31=0, bit 7=0, bits 30:25=0 and bits 11:8=0100. Slot B has opcode 0110011, 0010011 or 0110111 and a non-zero destination. One edge later the outputs are:
  - `fuse_valid`=1 and `consume_two`=1;
  - `fuse_kind`=2'b10 and `fuse_rd` equals the body destination;
  - `fuse_rs1` and `fuse_rs2` equal the branch sources, and `fuse_rs3`=0;
  - `cond_code` equals branch bits 14:12 and `body_word` equals slot B.
- R6: Skip fusion is refused in these cases:
  - any branch offset other than +8, including a backward offset;
  - a reserved branch condition (010, 011);
  - a body that is a branch (1100011), JAL (1101111), JALR (1100111) or a store (0100011).
- R7: When no pattern matches, `fuse_valid`, `consume_two`, `fuse_kind`, all register fields, `cond_code` and `body_word` are zero one edge later.
- R8: When `pair_valid` is low at an edge, no fusion is reported for that edge, whatever the words hold.
- R9: Only the two words sampled at the same edge are ever paired. A carry pair split by an unrelated instruction is not fused in either of the two adjacent windows.
- R10: `fuse_valid` rises for one cycle per fusible sample and drops the cycle after a non-fusible sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_valid | input | 1 | Both instruction slots hold real instructions |
| insn_a | input | 32 | Older instruction word |
| insn_b | input | 32 | Younger instruction word, directly after `insn_a` |
| fuse_valid | output | 1 | Pair issues as one fused operation |
| consume_two | output | 1 | Fetch advances by two slots |
| fuse_kind | output | 2 | 00 none, 01 carry-add, 10 predicated skip |
| fuse_rd | output | 5 | Destination register of the fused operation |
| fuse_rs1 | output | 5 | First compare source |
| fuse_rs2 | output | 5 | Second compare source |
| fuse_rs3 | output | 5 | Addend source for carry-add, zero otherwise |
| cond_code | output | 3 | Branch condition for the skip form |
| body_word | output | 32 | Guarded instruction for the skip form |

## Verification
Every result comes from a single output register. A pair driven before a rising edge is therefore reflected on all outputs right after that edge and on no earlier one. The bench changes inputs on a falling edge, lets exactly one rising edge pass, and reads the outputs at the next falling edge. Back-to-back windows hold each pair for one full cycle. This shows that the flag follows each sample alone and drops on the first non-fusible one.

// File: rtl/fuse_pkg.sv
// Shared constants and types for the pair fuser.
// Assumes 32-bit base-integer encodings with fields at their standard bit positions.
package fuse_pkg;
    localparam int ILEN = 32;
    localparam int RAW  = 5;

    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_CARRY = 2'b01,
        FK_SKIP  = 2'b10
    } fuse_kind_e;

    typedef struct packed {
        logic [6:0]     opc;
        logic [RAW-1:0] rd;
        logic [2:0]     f3;
        logic [RAW-1:0] rs1;
        logic [RAW-1:0] rs2;
        logic [6:0]     f7;
    } ifields_t;

    typedef struct packed {
        fuse_kind_e     kind;
        logic [RAW-1:0] rd;
        logic [RAW-1:0] rs1;
        logic [RAW-1:0] rs2;
        logic [RAW-1:0] rs3;
        logic [2:0]     cond;
    } fuse_res_t;
endpackage

// File: rtl/fuse_field_decode.sv
// Splits one instruction word into its register-type fields.
// Assumes a 32-bit word; meaning depends on the opcode and is judged downstream.
module fuse_field_decode
    import fuse_pkg::*;
(
    input  logic [ILEN-1:0] word,
    output ifields_t        fld
);
    // Pure bit slicing of the standard field positions.
    always_comb begin
        fld.opc = word[6:0];
        fld.rd  = word[11:7];
        fld.f3  = word[14:12];
        fld.rs1 = word[19:15];
        fld.rs2 = word[24:20];
        fld.f7  = word[31:25];
    end
endmodule

// File: rtl/fuse_skip_check.sv
// Decides whether a word's B-type immediate equals the skip distance.
// Assumes the caller has already checked that the word is a branch.
module fuse_skip_check
    import fuse_pkg::*;
#(
    parameter int SKIP_BYTES = 8
) (
    input  logic [ILEN-1:0] word,
    output logic            skip_hit
);
    localparam logic [12:0] SKIP_IMM = 13'(SKIP_BYTES);

    logic [12:0] imm_b;

    // Reassemble the scattered branch offset and compare to the skip distance.
    always_comb begin
        imm_b    = {word[31], word[7], word[30:25], word[11:8], 1'b0};
        skip_hit = (imm_b == SKIP_IMM);
    end
endmodule

// File: rtl/fuse_match.sv
// Pattern matcher for the two fusible pairings, purely combinational.
// Assumes slot A is older than slot B and both are adjacent in program order.
module fuse_match
    import fuse_pkg::*;
(
    input  logic      pair_valid,
    input  ifields_t  fa,
    input  ifields_t  fb,
    input  logic      a_skip_hit,
    output fuse_res_t res
);
    logic a_sltu, b_add, hit1, hit2, carry_ok;
    logic a_cond_ok, b_body_ok, skip_ok;

    // Carry-add pairing: one destination, carry read exactly once.
    always_comb begin
        a_sltu   = (fa.opc == OPC_OP) && (fa.f3 == 3'b011) && (fa.f7 == 7'd0);
        b_add    = (fb.opc == OPC_OP) && (fb.f3 == 3'b000) && (fb.f7 == 7'd0);
        hit1     = (fb.rs1 == fa.rd);
        hit2     = (fb.rs2 == fa.rd);
        carry_ok = a_sltu && b_add && (fb.rd == fa.rd) && (fa.rd != '0) && (hit1 ^ hit2);
    end

    // Skip pairing: short forward branch over one register-writing instruction.
    always_comb begin
        a_cond_ok = (fa.opc == OPC_BRANCH) && (fa.f3 != 3'b010) && (fa.f3 != 3'b011);
        b_body_ok = ((fb.opc == OPC_OP) || (fb.opc == OPC_OPIMM) || (fb.opc == OPC_LUI))
                    && (fb.rd != '0);
        skip_ok   = a_cond_ok && a_skip_hit && b_body_ok;
    end

    // Select the fused fields; all-zero when no pairing applies.
    always_comb begin
        res = '0;
        if (pair_valid && carry_ok) begin
            res.kind = FK_CARRY;
            res.rd   = fa.rd;
            res.rs1  = fa.rs1;
            res.rs2  = fa.rs2;
            res.rs3  = hit1 ? fb.rs2 : fb.rs1;
        end else if (pair_valid && skip_ok) begin
            res.kind = FK_SKIP;
            res.rd   = fb.rd;
            res.rs1  = fa.rs1;
            res.rs2  = fa.rs2;
            res.cond = fa.f3;
        end
    end
endmodule

// File: rtl/pair_fuse_detector.sv
// Decode-stage fuser: looks at two adjacent instruction words and registers
// a single fused operation when they form a carry-add or a skip-one pair.
// Assumes insn_b directly follows insn_a; results appear one edge after sampling.
module pair_fuse_detector
    import fuse_pkg::*;
#(
    parameter int SKIP_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_valid,
    input  logic [31:0]     insn_a,
    input  logic [31:0]     insn_b,
    output logic            fuse_valid,
    output logic            consume_two,
    output logic [1:0]      fuse_kind,
    output logic [4:0]      fuse_rd,
    output logic [4:0]      fuse_rs1,
    output logic [4:0]      fuse_rs2,
    output logic [4:0]      fuse_rs3,
    output logic [2:0]      cond_code,
    output logic [31:0]     body_word
);
    localparam int NSLOT = 2;

    logic [ILEN-1:0] slot_word [NSLOT];
    ifields_t        slot_fld  [NSLOT];
    logic            a_skip_hit;
    fuse_res_t       res_d;
    fuse_res_t       res_q;
    logic [ILEN-1:0] body_q;

    assign slot_word[0] = insn_a;
    assign slot_word[1] = insn_b;

    // One field decoder per slot.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        fuse_field_decode u_dec (
            .word (slot_word[g]),
            .fld  (slot_fld[g])
        );
    end

    fuse_skip_check #(.SKIP_BYTES(SKIP_BYTES)) u_skip (
        .word     (insn_a),
        .skip_hit (a_skip_hit)
    );

    fuse_match u_match (
        .pair_valid (pair_valid),
        .fa         (slot_fld[0]),
        .fb         (slot_fld[1]),
        .a_skip_hit (a_skip_hit),
        .res        (res_d)
    );

    // Output register: fused result plus the guarded body for the skip form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            body_q <= '0;
        end else begin
            res_q  <= res_d;
            body_q <= (res_d.kind == FK_SKIP) ? insn_b : '0;
        end
    end

    assign fuse_valid  = (res_q.kind != FK_NONE);
    assign consume_two = fuse_valid;
    assign fuse_kind   = res_q.kind;
    assign fuse_rd     = res_q.rd;
    assign fuse_rs1    = res_q.rs1;
    assign fuse_rs2    = res_q.rs2;
    assign fuse_rs3    = res_q.rs3;
    assign cond_code   = res_q.cond;
    assign body_word   = body_q;

    // Reset clears the result.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !fuse_valid && body_word == '0);

    // A fused destination is never x0.
    p_rd_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_valid |-> fuse_rd != '0);

    // Carry form never reads its own destination as the addend.
    p_addend_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_kind == FK_CARRY |-> fuse_rs3 != fuse_rd);

    // The guarded body is never a control-transfer instruction.
    p_body_not_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_kind == FK_SKIP |-> body_word[6:0] != OPC_BRANCH && body_word[6:0] != OPC_JAL
                                 && body_word[6:0] != OPC_JALR);

    // Idle outputs are fully zero.
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_valid |-> fuse_rd == '0 && fuse_rs3 == '0 && cond_code == '0 && body_word == '0);

    // An invalid sample never yields a fusion.
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(pair_valid) |-> !fuse_valid);
endmodule

// File: tb/pair_fuse_detector_tb.sv
module pair_fuse_detector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_valid = 1'b0;
    logic [31:0] insn_a = '0;
    logic [31:0] insn_b = '0;
    logic        fuse_valid, consume_two;
    logic [1:0]  fuse_kind;
    logic [4:0]  fuse_rd, fuse_rs1, fuse_rs2, fuse_rs3;
    logic [2:0]  cond_code;
    logic [31:0] body_word;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pair_fuse_detector u_dut (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .insn_a(insn_a), .insn_b(insn_b),
        .fuse_valid(fuse_valid), .consume_two(consume_two), .fuse_kind(fuse_kind),
        .fuse_rd(fuse_rd), .fuse_rs1(fuse_rs1), .fuse_rs2(fuse_rs2), .fuse_rs3(fuse_rs3),
        .cond_code(cond_code), .body_word(body_word)
    );

    localparam logic [6:0] OP = 7'b0110011, OPI = 7'b0010011, LUI = 7'b0110111;
    localparam logic [31:0] NOP = 32'h0000_0013;

    function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [4:0] rs2,
            input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, OP};
    endfunction

    function automatic logic [31:0] sltu(input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2);
        return rtype(7'd0, s2, s1, 3'b011, rd);
    endfunction

    function automatic logic [31:0] add(input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2);
        return rtype(7'd0, s2, s1, 3'b000, rd);
    endfunction

    function automatic logic [31:0] br(input logic [12:0] imm, input logic [4:0] s2,
            input logic [4:0] s1, input logic [2:0] f3);
        return {imm[12], imm[10:5], s2, s1, f3, imm[4:1], imm[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] addi(input logic [4:0] rd, input logic [4:0] s1, input logic [11:0] imm);
        return {imm, s1, 3'b000, rd, OPI};
    endfunction

    // Drive on a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic present(input logic v, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        pair_valid = v; insn_a = a; insn_b = b;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic v, input logic [1:0] k,
            input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
            input logic [4:0] r3, input logic [2:0] cc, input logic [31:0] body);
        logic [63:0] act, exp;
        act = {fuse_valid, consume_two, fuse_kind, fuse_rd, fuse_rs1, fuse_rs2, fuse_rs3, cond_code, body_word};
        exp = {v, v, k, rd, r1, r2, r3, cc, body};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_none(input string tag);
        expect_out(tag, 1'b0, 2'b00, 5'd0, 5'd0, 5'd0, 5'd0, 3'd0, 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        pair_valid = 1'b1; insn_a = sltu(5'd15, 5'd10, 5'd12); insn_b = add(5'd15, 5'd15, 5'd13);
        @(negedge clk);
        expect_none("R1 held in reset");
        @(negedge clk);
        expect_none("R1 still in reset");
        pair_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        expect_none("R1 first cycle after reset");
    endtask

    task automatic t_carry;
        present(1'b1, sltu(5'd15, 5'd10, 5'd12), add(5'd15, 5'd15, 5'd13));
        expect_out("R2 carry, d in first add source", 1'b1, 2'b01, 5'd15, 5'd10, 5'd12, 5'd13, 3'd0, 32'd0);
        present(1'b1, sltu(5'd15, 5'd10, 5'd12), add(5'd15, 5'd13, 5'd15));
        expect_out("R2 carry, d in second add source", 1'b1, 2'b01, 5'd15, 5'd10, 5'd12, 5'd13, 3'd0, 32'd0);
    endtask

    task automatic t_carry_reject;
        present(1'b1, sltu(5'd15, 5'd10, 5'd12), add(5'd14, 5'd15, 5'd13));
        expect_none("R3 add writes other register");
        present(1'b1, sltu(5'd15, 5'd10, 5'd12), add(5'd15, 5'd11, 5'd13));
        expect_none("R3 add does not read carry");
        present(1'b1, sltu(5'd15, 5'd10, 5'd12), add(5'd15, 5'd15, 5'd15));
        expect_none("R3 add reads carry twice");
    endtask

    task automatic t_zero_dest;
        present(1'b1, sltu(5'd0, 5'd10, 5'd12), add(5'd0, 5'd0, 5'd13));
        expect_none("R4 carry pair to x0");
        present(1'b1, br(13'd8, 5'd6, 5'd5, 3'b000), addi(5'd0, 5'd7, 12'd1));
        expect_none("R4 skip body to x0");
    endtask

    task automatic t_skip;
        logic [31:0] b1, b2;
        b1 = addi(5'd7, 5'd7, 12'd1);
        present(1'b1, br(13'd8, 5'd6, 5'd5, 3'b000), b1);
        expect_out("R5 skip beq over addi", 1'b1, 2'b10, 5'd7, 5'd5, 5'd6, 5'd0, 3'b000, b1);
        b2 = {20'h12345, 5'd20, LUI};
        present(1'b1, br(13'd8, 5'd9, 5'd8, 3'b111), b2);
        expect_out("R5 skip bgeu over lui", 1'b1, 2'b10, 5'd20, 5'd8, 5'd9, 5'd0, 3'b111, b2);
    endtask

    task automatic t_skip_reject;
        present(1'b1, br(13'd12, 5'd6, 5'd5, 3'b000), addi(5'd7, 5'd7, 12'd1));
        expect_none("R6 offset +12");
        present(1'b1, br(-13'sd8, 5'd6, 5'd5, 3'b001), addi(5'd7, 5'd7, 12'd1));
        expect_none("R6 offset -8");
        present(1'b1, br(13'd8, 5'd6, 5'd5, 3'b010), addi(5'd7, 5'd7, 12'd1));
        expect_none("R6 reserved condition");
        present(1'b1, br(13'd8, 5'd6, 5'd5, 3'b000), {20'd8, 5'd1, 7'b1101111});
        expect_none("R6 body jal");
        present(1'b1, br(13'd8, 5'd6, 5'd5, 3'b000), {7'd0, 5'd3, 5'd2, 3'b010, 5'd4, 7'b0100011});
        expect_none("R6 body store");
        present(1'b1, br(13'd8, 5'd6, 5'd5, 3'b000), br(13'd8, 5'd2, 5'd1, 3'b001));
        expect_none("R6 body branch");
    endtask

    task automatic t_nomatch;
        present(1'b1, add(5'd3, 5'd1, 5'd2), add(5'd4, 5'd3, 5'd2));
        expect_none("R7 two plain adds");
    endtask

    task automatic t_gate;
        present(1'b0, sltu(5'd15, 5'd10, 5'd12), add(5'd15, 5'd15, 5'd13));
        expect_none("R8 carry pair while invalid");
        present(1'b0, br(13'd8, 5'd6, 5'd5, 3'b000), addi(5'd7, 5'd7, 12'd1));
        expect_none("R8 skip pair while invalid");
    endtask

    task automatic t_separated;
        present(1'b1, sltu(5'd15, 5'd10, 5'd12), NOP);
        expect_none("R9 sltu then nop");
        present(1'b1, NOP, add(5'd15, 5'd15, 5'd13));
        expect_none("R9 nop then add");
    endtask

    task automatic t_pulse;
        present(1'b1, sltu(5'd9, 5'd1, 5'd2), add(5'd9, 5'd3, 5'd9));
        expect_out("R10 fuse high", 1'b1, 2'b01, 5'd9, 5'd1, 5'd2, 5'd3, 3'd0, 32'd0);
        present(1'b1, NOP, NOP);
        expect_none("R10 fuse drops next cycle");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_carry();
        t_carry_reject();
        t_zero_dest();
        t_skip();
        t_skip_reject();
        t_nomatch();
        t_gate();
        t_separated();
        t_pulse();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule